// File: doc/BRIEF.md
# Presettable Cascadable Down-Counter

This block is a synchronous binary down-counter of parameterised width (8 bits by default). It is meant for divide-by-n dividers, programmable timers and interrupt-interval generation. While no control is active, the count falls by one on every rising clock edge. When it passes zero it wraps to the all-ones value, so a free-running counter repeats every 2^WIDTH clocks.

Four controls act on the count. In falling priority they are:

- an asynchronous clear, which forces the all-ones value;
- an asynchronous preset, which forces the preset word in at once;
- a synchronous preset, which captures the preset word on the next rising edge;
- a hold input, which freezes counting.

A terminal-count output is active low. It reports a zero count only while the hold input is low. Several counters can therefore be chained: one stage's terminal output drives the next stage's hold input. Tying the synchronous preset of every stage to the last stage's terminal output gives a programmable divider.

Top module: `presettable_down_counter`

## Requirements
- R1: With clearN, jamNowN and jamNextN high and holdIn low, each rising clock edge lowers count by exactly one.
- R2: A low clearN forces count to all ones (255 for WIDTH=8) at once, without a clock edge, and overrides every other input including jamNowN.
- R3: A low jamNowN (with clearN high) copies preset into count at once, without a clock edge. While it stays low, each clock edge reloads preset instead of counting, whatever jamNextN and holdIn are.
- R4: A low jamNextN (with clearN and jamNowN high) loads preset into count on the next rising edge, even when holdIn is high.
- R5: With holdIn high and no load or clear active, count keeps its value across clock edges.
- R6: termCountN is low exactly when count equals zero and holdIn is low. It is driven combinationally from the count, so while counting it stays low for one full clock period.
- R7: From a count of zero with no control active, the next edge gives all ones, so a free-running cycle is 256 clocks long for WIDTH=8.
- R8: While holdIn is high, termCountN stays high even when count is zero.
- R9: Two stages share the clock. The low stage's termCountN drives the high stage's holdIn, and both stages' jamNextN are driven by the high stage's termCountN. After an asynchronous preset of N = 256·high + low, the high stage's termCountN first goes low after N clocks and then every N+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Asynchronous clear to all ones, active low |
| jamNowN | input | 1 | Asynchronous preset load, active low |
| jamNextN | input | 1 | Synchronous preset load, active low |
| holdIn | input | 1 | High inhibits counting and masks the terminal output |
| preset | input | WIDTH | Preset word shared by both loads |
| count | output | WIDTH | Current count value |
| termCountN | output | 1 | Terminal count, active low |

## Verification
The bench walks the counter through every value from all ones down past zero and back. A design that wrapped to zero, or stalled at zero, would break the 256-clock cycle. The same walk catches a terminal output that lasted more or less than one period. The synchronous preset is swept through all 256 words with the hold input high, and the terminal output is checked at a held zero. This exposes a load gated by the enable and a terminal output that ignores the hold. Mid-cycle pulses show whether the asynchronous preset really acts without a clock and whether the clear beats it. A two-stage divider is then timed for several 16-bit presets: off-by-one periods, or a high stage stepping on the wrong low-stage count, show up as wrong intervals.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  // Strobes from the control unit to the datapath, valid for one clock edge.
  typedef struct packed {
    logic loadPreset;  // capture preset on this edge
    logic stepDown;    // decrement (with wrap) on this edge
  } cntStrobes_t;

endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import dcnt_pkg::*;
(
  input  logic        jamNextN,
  input  logic        holdIn,
  input  logic        isZero,
  output cntStrobes_t strobes,
  output logic        termCountN
);

  logic loadReq;
  logic countReq;

  // The synchronous load wins over the hold; counting needs hold low.
  always_comb begin
    loadReq  = ~jamNextN;
    countReq = ~holdIn;
    strobes.loadPreset = loadReq;
    strobes.stepDown   = countReq & ~loadReq;
  end

  // The terminal output is active low and gated by the hold input.
  always_comb begin
    termCountN = ~(isZero & ~holdIn);
  end

endmodule

// File: rtl/dcnt_datapath.sv
module dcnt_datapath
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             jamNowN,
  input  logic [WIDTH-1:0] preset,
  input  cntStrobes_t      strobes,
  output logic [WIDTH-1:0] count,
  output logic             isZero
);

  localparam logic [WIDTH-1:0] MAX_COUNT = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE       = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cntQ;
  logic [WIDTH-1:0] stepVal;
  logic [WIDTH-1:0] nextVal;

  // Zero detect, shared by the wrap logic and the terminal output.
  always_comb begin
    isZero = (cntQ == '0);
  end

  // From zero the count wraps to all ones rather than stopping.
  always_comb begin
    stepVal = isZero ? MAX_COUNT : (cntQ - ONE);
  end

  always_comb begin
    if (strobes.loadPreset)    nextVal = preset;
    else if (strobes.stepDown) nextVal = stepVal;
    else                       nextVal = cntQ;
  end

  // Two asynchronous paths: the clear outranks the asynchronous preset.
  always_ff @(posedge clk or negedge clearN or negedge jamNowN) begin
    if (!clearN)       cntQ <= MAX_COUNT;
    else if (!jamNowN) cntQ <= preset;
    else               cntQ <= nextVal;
  end

  assign count = cntQ;

endmodule

// File: rtl/presettable_down_counter.sv
module presettable_down_counter
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             jamNowN,
  input  logic             jamNextN,
  input  logic             holdIn,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             termCountN
);

  cntStrobes_t strobes;
  logic        isZero;

  dcnt_ctrl uCtrl (
    .jamNextN  (jamNextN),
    .holdIn    (holdIn),
    .isZero    (isZero),
    .strobes   (strobes),
    .termCountN(termCountN)
  );

  dcnt_datapath #(.WIDTH(WIDTH)) uPath (
    .clk    (clk),
    .clearN (clearN),
    .jamNowN(jamNowN),
    .preset (preset),
    .strobes(strobes),
    .count  (count),
    .isZero (isZero)
  );

endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clearN,
  input logic             jamNowN,
  input logic             jamNextN,
  input logic             holdIn,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             termCountN
);

  // R1
  step_down_chk: assert property (@(posedge clk) disable iff (!clearN)
    (jamNowN && jamNextN && !holdIn) ##1 jamNowN |-> count == WIDTH'($past(count) - 1'b1));

  // R2
  clear_value_chk: assert property (@(posedge clk) disable iff (!clearN)
    ($rose(clearN) && jamNowN && $past(jamNowN)) |-> count == {WIDTH{1'b1}});

  // R3
  async_load_chk: assert property (@(posedge clk) disable iff (!clearN)
    (!jamNowN && $stable(preset)) |-> count == preset);

  // R4
  sync_load_chk: assert property (@(posedge clk) disable iff (!clearN)
    (jamNowN && !jamNextN) ##1 jamNowN |-> count == $past(preset));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!clearN)
    (jamNowN && jamNextN && holdIn) ##1 jamNowN |-> $stable(count));

  // R6
  term_zero_chk: assert property (@(posedge clk) disable iff (!clearN)
    !termCountN |-> count == '0);

  // R8
  term_masked_chk: assert property (@(posedge clk) disable iff (!clearN)
    holdIn |-> termCountN);

endmodule

bind presettable_down_counter dcnt_checker #(.WIDTH(WIDTH)) uChk (
  .clk       (clk),
  .clearN    (clearN),
  .jamNowN   (jamNowN),
  .jamNextN  (jamNextN),
  .holdIn    (holdIn),
  .preset    (preset),
  .count     (count),
  .termCountN(termCountN)
);

// File: tb/sim_presettable_down_counter.sv
`timescale 1ns/1ps
module sim_presettable_down_counter;

  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Single counter under test.
  logic         clearN = 1'b0, jamNowN = 1'b1, jamNextN = 1'b1, holdIn = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         termCountN;

  presettable_down_counter #(.WIDTH(W)) u0 (
    .clk(clk), .clearN(clearN), .jamNowN(jamNowN), .jamNextN(jamNextN),
    .holdIn(holdIn), .preset(preset), .count(count), .termCountN(termCountN)
  );

  // Two-stage divider.
  logic         casClrN = 1'b0, casJamN = 1'b1;
  logic [W-1:0] nLo = '0, nHi = '0;
  logic [W-1:0] cntLo, cntHi;
  logic         termLoN, termHiN;
  logic         loLow = 1'b0;

  presettable_down_counter #(.WIDTH(W)) uLow (
    .clk(clk), .clearN(casClrN), .jamNowN(casJamN), .jamNextN(termHiN),
    .holdIn(loLow), .preset(nLo), .count(cntLo), .termCountN(termLoN)
  );
  presettable_down_counter #(.WIDTH(W)) uHigh (
    .clk(clk), .clearN(casClrN), .jamNowN(casJamN), .jamNextN(termHiN),
    .holdIn(termLoN), .preset(nHi), .count(cntHi), .termCountN(termHiN)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Advance one edge and land 2 ns after it, well away from the next edge.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic runDivider(input int n);
    int cyc;
    casJamN = 1'b0;
    nLo = W'(n % 256);
    nHi = W'(n / 256);
    step();
    casJamN = 1'b1;
    // One edge has passed while the preset was still forced.
    cyc = 0;
    while (termHiN && cyc < 70000) begin
      step();
      cyc++;
    end
    check("R9 first interval", cyc, n);
    cyc = 0;
    do begin
      step();
      cyc++;
    end while (termHiN && cyc < 70000);
    check("R9 period", cyc, n + 1);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2 reset state
    #12;
    check("R2 reset count", count, 255);
    check("R6 reset term", termCountN, 1);
    step();
    clearN = 1'b1;

    // R1, R6, R7: full free-running lap from 255 down through zero.
    for (int k = 1; k <= 256; k++) begin
      int exp;
      step();
      exp = (255 - k) & 8'hFF;
      check("R1/R7 count", count, exp);
      check("R6 term", termCountN, (exp == 0) ? 0 : 1);
    end
    check("R7 lap ends at all ones", count, 255);

    // R5: hold freezes the count.
    holdIn = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R5 hold", count, 255);
    end

    // R4, R8: synchronous load of every word with hold high.
    for (int v = 0; v < 256; v++) begin
      jamNextN = 1'b0;
      preset = W'(v);
      step();
      check("R4 sync load", count, v);
      check("R8 term masked", termCountN, 1);
    end
    jamNextN = 1'b1;
    // The count is now 255. Load zero and hold it.
    jamNextN = 1'b0;
    preset = '0;
    step();
    jamNextN = 1'b1;
    step();
    check("R8 zero held term", termCountN, 1);
    holdIn = 1'b0;
    #1;
    check("R6 zero term", termCountN, 0);
    step();
    check("R6 term one period", termCountN, 1);
    check("R7 wrap", count, 255);

    // R3: asynchronous preset acts mid-cycle and outranks the sync load.
    preset = 8'h5A;
    jamNextN = 1'b0;
    #1;
    jamNowN = 1'b0;
    #1;
    check("R3 async immediate", count, 8'h5A);
    preset = 8'h21;
    jamNextN = 1'b1;
    step();
    check("R3 reload while low", count, 8'h21);
    step();
    check("R3 no count while low", count, 8'h21);
    jamNowN = 1'b1;
    step();
    check("R1 after async", count, 8'h20);

    // R2: clear outranks a simultaneous asynchronous preset.
    preset = 8'h33;
    jamNowN = 1'b0;
    #1;
    check("R3 second async", count, 8'h33);
    clearN = 1'b0;
    #1;
    check("R2 clear over async", count, 255);
    step();
    check("R2 clear held at edge", count, 255);
    jamNowN = 1'b1;
    #1;
    clearN = 1'b1;
    step();
    check("R1 after clear", count, 254);

    // R9: two-stage divider.
    casClrN = 1'b1;
    runDivider(5);
    runDivider(16'h0100);
    runDivider(16'h01FF);
    runDivider(16'h0A37);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule